// File: doc/BRIEF.md
# Weight-Stationary Convolution Row Array

This block computes one output row of a one-dimensional convolution with a chain of K multiply-accumulate elements. Each element keeps one filter tap in a local register for the whole input row. Every accepted activation goes to all elements in the same cycle. Each element adds its product to the running sum from its left neighbour, registers the result and passes it to the right. The sum leaving the last element is one output position of the row. Because neighbouring elements hold adjacent window positions, a new output can complete on every accepted activation once the window is full.

A partial-sum stream enters at the head of the chain together with the activations. A multi-row filter can then be built up over several passes: the caller feeds the sums from the previous filter row back in, or zeros on the first pass. The output is either a final sum or a partial sum that the caller keeps for the next pass. Taps are loaded serially between rows. A small controller has three states. Idle means no activation of the current row has been accepted yet. Fill means some activations have been accepted but the window is not full. Emit means each further accepted activation completes an output. The transitions are: Idle to Fill on a non-final activation; Fill to Emit when the window becomes full; Idle to Emit directly when K is 1 or 2; and Fill or Emit back to Idle on the activation flagged as last. A last activation accepted in Idle keeps the controller in Idle.

Top module: `wsr_conv_row`

## Requirements
- R1: After reset, `sum_valid` is low, `sum_data` is zero and all taps are zero.
- R2: A tap load happens when `wt_load` is high, `act_valid` is low and no row is in progress. It shifts the taps: `wt_data` enters tap K-1 and each tap k takes the old value of tap k+1. After K loads, the first value loaded is tap 0.
- R3: A tap load request is ignored while a row is in progress, and also in any cycle where `act_valid` is high. The taps keep their values, and every later output is computed with the old taps.
- R4: Output j of a row equals psum[j] + Σ tap[k]·x[j+k] for k = 0..K-1. Here x[i] is the i-th accepted activation of the row (counting from 0), and psum[j] is the `psum_in` value sampled with x[j]. All values are two's complement. Taps and activations are DW-bit values, and the sum wraps modulo 2^AW.
- R5: `sum_valid` is high in the cycle right after the activation x[j+K-1] is accepted, and only then. With no stalls, the first output of a row is valid K cycles after the first activation is presented.
- R6: A row of W accepted activations with W ≥ K gives exactly W-K+1 outputs. A row with W < K gives none.
- R7: In the cycle after a cycle with `act_valid` low, `sum_valid` is low and `sum_data` is unchanged. No output is lost or repeated across a stall.
- R8: A `psum_in` value sampled with an activation x[j] where j > W-K never reaches any output. `psum_in` is ignored when `act_valid` is low.
- R9: An accepted activation with `act_last` high ends the row. The next accepted activation is x[0] of a new row, and nothing carries over into the new row's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_load | input | 1 | Tap load request |
| wt_data | input | DW | Tap value to shift in (signed) |
| act_valid | input | 1 | Activation present this cycle |
| act_data | input | DW | Activation, broadcast to every element (signed) |
| act_last | input | 1 | Marks the final activation of a row |
| psum_in | input | AW | Incoming partial sum, sampled with the activation (signed) |
| sum_valid | output | 1 | An output position completed |
| sum_data | output | AW | Completed sum from the chain's tail (signed) |

## Verification
A tap load and an activation can arrive in the same cycle. A load can also be requested during a stall in the middle of a row. Both cases are provoked: the sweeps assert `wt_load` on alternate activations and on every stall cycle, and also run a dedicated row with loads mid-stream. A reference model updates its taps only on the cycles R2 allows. Each output in the rest of that row and in the following row is compared against sums built from the expected taps, so a wrongly accepted load shows up as a wrong sum.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_EMIT = 2'd2
    } row_state_e;
endpackage

// File: rtl/wsr_weight_bank.sv
module wsr_weight_bank #(
    parameter int K  = 3,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic [DW-1:0]   shift_in,
    output logic [K*DW-1:0] taps_flat
);
    // Serial tap register: new value enters the top tap, older values move down.
    for (genvar g = 0; g < K; g++) begin : g_tap
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                taps_flat[g*DW +: DW] <= '0;
            end else if (shift_en) begin
                if (g == K - 1) begin
                    taps_flat[g*DW +: DW] <= shift_in;
                end else begin
                    taps_flat[g*DW +: DW] <= taps_flat[(g+1)*DW +: DW];
                end
            end
        end
    end
endmodule

// File: rtl/wsr_pe.sv
module wsr_pe #(
    parameter int DW = 8,
    parameter int AW = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] weight,
    input  logic signed [DW-1:0] act,
    input  logic signed [AW-1:0] psum_prev,
    output logic signed [AW-1:0] psum_out
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0] prod;

    assign prod = weight * act;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psum_out <= '0;
        end else if (en) begin
            psum_out <= psum_prev + AW'(prod);
        end
    end
endmodule

// File: rtl/wsr_row_ctrl.sv
module wsr_row_ctrl
    import wsr_pkg::*;
#(
    parameter int K = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       act_valid,
    input  logic       act_last,
    input  logic       wt_load,
    output logic       load_ok,
    output logic       out_valid,
    output row_state_e state
);
    localparam int CW = (K > 1) ? $clog2(K) : 1;
    localparam logic [CW-1:0] FULL = CW'(K - 1);

    row_state_e     state_nxt;
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  cnt_nxt;
    logic           emit;

    // Next-state logic
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (act_valid && !act_last) begin
                    if (K == 1) begin
                        state_nxt = ST_EMIT;
                    end else begin
                        cnt_nxt   = CW'(1);
                        state_nxt = (K == 2) ? ST_EMIT : ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                if (act_valid) begin
                    if (act_last) begin
                        cnt_nxt   = '0;
                        state_nxt = ST_IDLE;
                    end else begin
                        cnt_nxt   = cnt + CW'(1);
                        state_nxt = (cnt + CW'(1) == FULL) ? ST_EMIT : ST_FILL;
                    end
                end
            end
            ST_EMIT: begin
                if (act_valid && act_last) begin
                    cnt_nxt   = '0;
                    state_nxt = ST_IDLE;
                end
            end
            default: begin
                cnt_nxt   = '0;
                state_nxt = ST_IDLE;
            end
        endcase
    end

    assign emit    = act_valid && (cnt == FULL);
    assign load_ok = wt_load && !act_valid && (state == ST_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= emit;
        end
    end
endmodule

// File: rtl/wsr_conv_row.sv
module wsr_conv_row
    import wsr_pkg::*;
#(
    parameter int K  = 3,
    parameter int DW = 8,
    parameter int AW = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wt_load,
    input  logic [DW-1:0]        wt_data,
    input  logic                 act_valid,
    input  logic signed [DW-1:0] act_data,
    input  logic                 act_last,
    input  logic signed [AW-1:0] psum_in,
    output logic                 sum_valid,
    output logic signed [AW-1:0] sum_data
);
    logic [K*DW-1:0]      taps_flat;
    logic                 load_ok;
    row_state_e           row_state;
    logic signed [AW-1:0] chain [K+1];

    assign chain[0] = psum_in;

    wsr_row_ctrl #(.K(K)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_valid (act_valid),
        .act_last  (act_last),
        .wt_load   (wt_load),
        .load_ok   (load_ok),
        .out_valid (sum_valid),
        .state     (row_state)
    );

    wsr_weight_bank #(.K(K), .DW(DW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (load_ok),
        .shift_in  (wt_data),
        .taps_flat (taps_flat)
    );

    for (genvar g = 0; g < K; g++) begin : g_pe
        wsr_pe #(.DW(DW), .AW(AW)) u_pe (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (act_valid),
            .weight    (taps_flat[g*DW +: DW]),
            .act       (act_data),
            .psum_prev (chain[g]),
            .psum_out  (chain[g+1])
        );
    end

    assign sum_data = chain[K];
endmodule

// File: rtl/wsr_conv_row_chk.sv
module wsr_conv_row_chk
    import wsr_pkg::*;
#(
    parameter int K  = 3,
    parameter int DW = 8,
    parameter int AW = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wt_load,
    input logic [DW-1:0]   wt_data,
    input logic            act_valid,
    input logic            act_last,
    input logic            sum_valid,
    input logic [AW-1:0]   sum_data,
    input row_state_e      state,
    input logic [K*DW-1:0] taps_flat
);
    a_r2_load_shifts: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_load && !act_valid && state == ST_IDLE) |=> (taps_flat[K*DW-1 -: DW] == $past(wt_data)));

    a_r3_load_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_load && (act_valid || state != ST_IDLE)) |=> $stable(taps_flat));

    a_r5_valid_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid |-> $past(act_valid));

    a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !act_valid |=> (!sum_valid && $stable(sum_data)));

    a_r9_last_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_last) |=> (state == ST_IDLE));
endmodule

bind wsr_conv_row wsr_conv_row_chk #(.K(K), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wt_load   (wt_load),
    .wt_data   (wt_data),
    .act_valid (act_valid),
    .act_last  (act_last),
    .sum_valid (sum_valid),
    .sum_data  (sum_data),
    .state     (row_state),
    .taps_flat (taps_flat)
);

// File: tb/tb_wsr_conv_row.sv
module tb_wsr_conv_row;
    localparam int K  = 3;
    localparam int DW = 8;
    localparam int AW = 24;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 wt_load = 1'b0;
    logic [DW-1:0]        wt_data = '0;
    logic                 act_valid = 1'b0;
    logic signed [DW-1:0] act_data = '0;
    logic                 act_last = 1'b0;
    logic signed [AW-1:0] psum_in = '0;
    logic                 sum_valid;
    logic signed [AW-1:0] sum_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    longint wm [K];
    longint xs [64];
    longint ps [64];
    int     idx = 0;
    bit     in_row = 1'b0;
    int     row_outs = 0;
    logic signed [AW-1:0] last_out = '0;

    always #10 clk = ~clk;

    wsr_conv_row #(.K(K), .DW(DW), .AW(AW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wt_load   (wt_load),
        .wt_data   (wt_data),
        .act_valid (act_valid),
        .act_data  (act_data),
        .act_last  (act_last),
        .psum_in   (psum_in),
        .sum_valid (sum_valid),
        .sum_data  (sum_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle (called at a negedge), then check at the next negedge.
    task automatic step(input bit v, input int a, input longint p, input bit last,
                        input bit ld, input int ldv);
        bit              exp_v = 1'b0;
        longint          exp_s = 0;
        logic [AW-1:0]   e;
        int              w_row = 0;
        act_valid = v;
        act_data  = DW'(a);
        psum_in   = AW'(p);
        act_last  = last;
        wt_load   = ld;
        wt_data   = DW'(ldv);
        // R2/R3: only an idle, activation-free cycle accepts a load
        if (ld && !v && !in_row) begin
            for (int k = 0; k < K - 1; k++) wm[k] = wm[k+1];
            wm[K-1] = longint'($signed(DW'(ldv)));
        end
        if (v) begin
            xs[idx] = a;
            ps[idx] = p;
            if (idx >= K - 1) begin
                int j = idx - K + 1;
                exp_v = 1'b1;
                exp_s = ps[j];
                for (int k = 0; k < K; k++) exp_s += wm[k] * xs[j+k];
            end
            w_row  = idx + 1;
            idx    = last ? 0 : idx + 1;
            in_row = !last;
        end
        @(negedge clk);
        chk(sum_valid == exp_v, "R5,R6 sum_valid", longint'(sum_valid), longint'(exp_v));
        if (exp_v) begin
            e = exp_s[AW-1:0];
            row_outs++;
            chk(sum_data == e, "R4,R8 sum_data", longint'(sum_data), longint'($signed(e)));
        end
        if (!v) begin
            chk(sum_data == last_out, "R7 stall hold", longint'(sum_data), longint'(last_out));
        end
        last_out = sum_data;
        if (v && last) begin
            int exp_n = (w_row >= K) ? (w_row - K + 1) : 0;
            chk(row_outs == exp_n, "R6 R9 row output count", row_outs, exp_n);
            row_outs = 0;
        end
    endtask

    task automatic load_tap(input int val);
        step(1'b0, 0, 0, 1'b0, 1'b1, val);
    endtask

    initial begin
        for (int k = 0; k < K; k++) wm[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(sum_valid == 1'b0, "R1 sum_valid after reset", longint'(sum_valid), 0);
        chk(sum_data == '0, "R1 sum_data after reset", longint'(sum_data), 0);

        // R2: serial load order, first value ends in tap 0
        load_tap(1);
        load_tap(2);
        load_tap(3);
        for (int i = 0; i < 6; i++) step(1'b1, i + 1, 0, i == 5, 1'b0, 0);

        // Near-exhaustive sweep: tap sets x row lengths, with stalls and load requests
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < K; k++) load_tap(((s * 53 + k * 29) % 256) - 128);
            for (int w = 1; w <= 8; w++) begin
                for (int i = 0; i < w; i++) begin
                    if ((i + w + s) % 3 == 0) step(1'b0, 0, 0, 1'b0, 1'b1, 99); // R3 R7
                    step(1'b1, ((i * 37 + w * 11 + s * 5) % 256) - 128,
                         longint'(i * 1000 - w * 777 + s * 31), i == w - 1,
                         (i % 2) == 1, 77);
                end
            end
        end

        // R3: loads mid-row and alongside activations, then a full row on old taps
        for (int k = 0; k < K; k++) load_tap(k - 2);
        step(1'b1, 10, 5, 1'b0, 1'b0, 0);
        step(1'b1, -20, 6, 1'b0, 1'b1, 55);
        step(1'b0, 0, 0, 1'b0, 1'b1, 66);
        step(1'b1, 30, 7, 1'b0, 1'b1, 44);
        step(1'b0, 0, 0, 1'b0, 1'b1, 33);
        step(1'b1, 40, 8, 1'b1, 1'b0, 0);
        for (int i = 0; i < 5; i++) step(1'b1, 3 * i - 7, i, i == 4, 1'b0, 0);

        // R4: wraparound at the accumulator width
        for (int k = 0; k < K; k++) load_tap(-128);
        for (int i = 0; i < 4; i++) step(1'b1, -128, 64'sd8388607, i == 3, 1'b0, 0);

        // R9: back-to-back single rows shorter than the window
        step(1'b1, 5, 1, 1'b1, 1'b0, 0);
        step(1'b1, 6, 2, 1'b1, 1'b0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule